// File: doc/BRIEF.md
# Reference Divider with Phase-Frequency Detector and Test Output Router

The block sits in the digital part of a synthesizer loop. It divides an incoming reference clock by one of three programmable ratios. It compares each divided reference event with a rising edge of the already divided feedback clock in a three-state phase-frequency detector. The detector drives three mutually exclusive charge-pump enables: source, sink and high impedance. A polarity bit swaps the source and sink enables, so loops with either VCO slope can be served.

A lock monitor measures how long the detector holds one side alone in each comparison. After a run of short comparisons it raises a lock flag, and it drops the flag on the first over-long pulse. A single output pin carries either the lock flag or one of several divided internal clocks, selected by a 3-bit test field. The upper half of the test codes also forces the charge pump to high impedance, so the loop can be opened while the pin is being observed.

All logic runs on the reference clock. The feedback input is sampled on that clock, so phase differences are seen in whole reference periods.

Top module: `refpfd_top`

## Requirements
- R1: Ratio code 01 divides by 12, 10 by 16 and 11 by 24. The divided reference level is high for the first half of each period, starting in the cycle in which the ratio becomes valid or reset ends.
- R2: Ratio code 00 is illegal. It holds the divider at zero with the divided reference level low, keeps the detector idle and the charge pump in high impedance, and ignores feedback edges.
- R3: With polarity bit 0, source is enabled (sink and high-Z off) while only the reference-side detector flop is set. This is the case when the reference leads.
- R4: With polarity bit 1, the same condition enables sink instead of source, and the feedback-only condition enables source.
- R5: When neither detector flop is set, or both are set (including coincident reference and feedback events), the charge pump is in high impedance.
- R6: One clock after both detector flops are set, both are cleared, so the next comparison starts from the idle state.
- R7: With test codes 000, 001, 010 and 011, the output pin shows, in that order: the lock flag, the divided reference level, the sampled feedback (one cycle after the input), and the reference divided by a further 2048 (the MSB of a counter of reference events). The charge pump works normally.
- R8: Test codes 100 to 111 force high impedance (source and sink off). The pin then shows, in order: the lock flag, the divided reference level, the sampled feedback, and the reference divided by a further 2 (toggling on each reference event).
- R9: The lock flag is 1 when locked and 0 when unlocked. It becomes 1 one cycle after the fourth consecutive comparison in which the one-sided pulse lasted fewer than 2 reference cycles.
- R10: In the cycle in which a one-sided pulse reaches its second reference cycle, the lock run restarts; the lock flag is 0 from the next cycle on.
- R11: A low level on the synchronous active-low power-up input clears the divider, the detector, the lock monitor and the slow dividers. While it is low, the pin shows 0 under test code 000 and the charge pump is in high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| pup_rst_n | input | 1 | Synchronous power-up, low holds everything in reset |
| ratio_sel | input | 2 | Reference ratio code (01:12, 10:16, 11:24, 00 illegal) |
| pol_swap | input | 1 | Detector polarity, 1 swaps source and sink |
| test_sel | input | 3 | Output pin source; bit 2 forces high impedance |
| fb_div_in | input | 1 | Divided feedback clock |
| cp_src_en | output | 1 | Charge-pump source enable |
| cp_snk_en | output | 1 | Charge-pump sink enable |
| cp_hiz_en | output | 1 | Charge-pump high-impedance enable |
| ld_out | output | 1 | Lock flag or selected test signal |

## Verification
Two paths can act in the same cycle: the reference event from the divider and the feedback edge from the pin. The bench lines them up exactly by raising the feedback one cycle before the computed reference event. It then expects high impedance from that cycle on, no source pulse at all, and a lock flag that stays high because the comparison still counts as short. In a second overlap, a forced high-impedance test code is applied during a real leading pulse. The bench expects the enables to stay off while the pin still reports the lock flag that this pulse keeps alive.

// File: rtl/refpfd_pkg.sv
`timescale 1ns/1ps
package refpfd_pkg;

  typedef enum logic [1:0] {
    LD_LOCK = 2'd0,
    LD_REF  = 2'd1,
    LD_FB   = 2'd2,
    LD_SLOW = 2'd3
  } ld_pick_e;

  // Division ratio for a ratio code; 0 marks the illegal code.
  function automatic int unsigned ratio_of(input logic [1:0] code,
                                           input int unsigned div_a,
                                           input int unsigned div_b,
                                           input int unsigned div_c);
    case (code)
      2'b01:   return div_a;
      2'b10:   return div_b;
      2'b11:   return div_c;
      default: return 0;
    endcase
  endfunction

  function automatic logic ratio_ok(input logic [1:0] code);
    return code != 2'b00;
  endfunction

  // A comparison is short when its one-sided pulse stayed below the limit.
  function automatic logic pulse_ok(input int unsigned width,
                                    input int unsigned limit);
    return width < limit;
  endfunction

endpackage

// File: rtl/ref_divider.sv
`timescale 1ns/1ps
module ref_divider
  import refpfd_pkg::*;
#(
  parameter int unsigned DIV_A = 12,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 24
) (
  input  logic       clk,
  input  logic       pup_rst_n,
  input  logic [1:0] ratio_sel,
  output logic       div_valid,
  output logic       ref_tick,
  output logic       ref_lvl
);
  localparam int unsigned MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int unsigned CNT_W  = $clog2(MAX_D);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_ext;
  logic [31:0]      div_n;

  always_comb begin
    div_valid = ratio_ok(ratio_sel);
    div_n     = ratio_of(ratio_sel, DIV_A, DIV_B, DIV_C);
    cnt_ext   = {{(32-CNT_W){1'b0}}, cnt_q};
    // ">=" keeps a ratio change to a shorter value from overrunning
    ref_tick  = div_valid && (cnt_ext >= div_n - 32'd1);
    ref_lvl   = div_valid && (cnt_ext < (div_n >> 1));
  end

  always_ff @(posedge clk) begin
    if (!pup_rst_n || !div_valid) cnt_q <= '0;
    else if (ref_tick)            cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core (
  input  logic clk,
  input  logic pup_rst_n,
  input  logic enable,
  input  logic ref_tick,
  input  logic fb_div_in,
  output logic fb_rise,
  output logic fb_lvl,
  output logic up_q,
  output logic dn_q
);
  logic fb_q;
  logic both_set;

  assign fb_rise  = fb_div_in & ~fb_q;
  assign fb_lvl   = fb_q;
  assign both_set = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (!pup_rst_n) fb_q <= 1'b0;
    else            fb_q <= fb_div_in;
  end

  // Both flops clear one cycle after both are set; a fresh event in that
  // same cycle still registers.
  always_ff @(posedge clk) begin
    if (!pup_rst_n || !enable) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= (up_q & ~both_set) | ref_tick;
      dn_q <= (dn_q & ~both_set) | fb_rise;
    end
  end
endmodule

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor
  import refpfd_pkg::*;
#(
  parameter int unsigned WIDTH_LIMIT = 2,
  parameter int unsigned LOCK_RUNS   = 4
) (
  input  logic clk,
  input  logic pup_rst_n,
  input  logic enable,
  input  logic up_q,
  input  logic dn_q,
  output logic good_evt,
  output logic viol_evt,
  output logic locked
);
  localparam int unsigned W_W = $clog2(WIDTH_LIMIT + 1);
  localparam int unsigned L_W = $clog2(LOCK_RUNS + 1);

  logic [W_W-1:0] wid_q;
  logic [L_W-1:0] run_q;
  logic           one_side;
  logic           both_set;

  always_comb begin
    one_side = up_q ^ dn_q;
    both_set = up_q & dn_q;
    viol_evt = one_side && (32'(wid_q) == WIDTH_LIMIT - 1);
    good_evt = both_set && pulse_ok(32'(wid_q), WIDTH_LIMIT);
    locked   = (32'(run_q) == LOCK_RUNS);
  end

  always_ff @(posedge clk) begin
    if (!pup_rst_n || !enable) wid_q <= '0;
    else if (both_set)         wid_q <= '0;
    else if (one_side && (32'(wid_q) < WIDTH_LIMIT))
                               wid_q <= wid_q + W_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!pup_rst_n || !enable) run_q <= '0;
    else if (viol_evt)         run_q <= '0;
    else if (good_evt && !locked)
                               run_q <= run_q + L_W'(1);
  end
endmodule

// File: rtl/test_route.sv
`timescale 1ns/1ps
module test_route
  import refpfd_pkg::*;
#(
  parameter int unsigned SLOW_LOG2 = 11
) (
  input  logic       clk,
  input  logic       pup_rst_n,
  input  logic       ref_tick,
  input  logic [2:0] test_sel,
  input  logic       pol_swap,
  input  logic       locked,
  input  logic       ref_lvl,
  input  logic       fb_lvl,
  input  logic       up_q,
  input  logic       dn_q,
  output logic       cp_src_en,
  output logic       cp_snk_en,
  output logic       cp_hiz_en,
  output logic       ld_out
);
  logic [SLOW_LOG2-1:0] slow_q;
  logic                 half_q;
  logic                 force_hiz;
  logic                 drive_up;
  logic                 drive_dn;
  ld_pick_e             pick;

  always_ff @(posedge clk) begin
    if (!pup_rst_n) begin
      slow_q <= '0;
      half_q <= 1'b0;
    end else if (ref_tick) begin
      slow_q <= slow_q + SLOW_LOG2'(1);
      half_q <= ~half_q;
    end
  end

  always_comb begin
    force_hiz = test_sel[2];
    drive_up  = pol_swap ? dn_q : up_q;
    drive_dn  = pol_swap ? up_q : dn_q;
    cp_src_en = !force_hiz && drive_up && !drive_dn;
    cp_snk_en = !force_hiz && drive_dn && !drive_up;
    cp_hiz_en = !(cp_src_en || cp_snk_en);
    pick      = ld_pick_e'(test_sel[1:0]);
    case (pick)
      LD_LOCK: ld_out = locked;
      LD_REF:  ld_out = ref_lvl;
      LD_FB:   ld_out = fb_lvl;
      default: ld_out = force_hiz ? half_q : slow_q[SLOW_LOG2-1];
    endcase
  end
endmodule

// File: rtl/refpfd_top.sv
`timescale 1ns/1ps
module refpfd_top #(
  parameter int unsigned DIV_A       = 12,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 24,
  parameter int unsigned WIDTH_LIMIT = 2,
  parameter int unsigned LOCK_RUNS   = 4,
  parameter int unsigned SLOW_LOG2   = 11
) (
  input  logic       clk,
  input  logic       pup_rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       pol_swap,
  input  logic [2:0] test_sel,
  input  logic       fb_div_in,
  output logic       cp_src_en,
  output logic       cp_snk_en,
  output logic       cp_hiz_en,
  output logic       ld_out
);
  logic div_valid;
  logic ref_tick;
  logic ref_lvl;
  logic fb_rise;
  logic fb_lvl;
  logic up_q;
  logic dn_q;
  logic good_evt;
  logic viol_evt;
  logic locked;

  ref_divider #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_div (
    .clk       (clk),
    .pup_rst_n (pup_rst_n),
    .ratio_sel (ratio_sel),
    .div_valid (div_valid),
    .ref_tick  (ref_tick),
    .ref_lvl   (ref_lvl)
  );

  pfd_core u_pfd (
    .clk       (clk),
    .pup_rst_n (pup_rst_n),
    .enable    (div_valid),
    .ref_tick  (ref_tick),
    .fb_div_in (fb_div_in),
    .fb_rise   (fb_rise),
    .fb_lvl    (fb_lvl),
    .up_q      (up_q),
    .dn_q      (dn_q)
  );

  lock_monitor #(.WIDTH_LIMIT(WIDTH_LIMIT), .LOCK_RUNS(LOCK_RUNS)) u_lock (
    .clk       (clk),
    .pup_rst_n (pup_rst_n),
    .enable    (div_valid),
    .up_q      (up_q),
    .dn_q      (dn_q),
    .good_evt  (good_evt),
    .viol_evt  (viol_evt),
    .locked    (locked)
  );

  test_route #(.SLOW_LOG2(SLOW_LOG2)) u_route (
    .clk       (clk),
    .pup_rst_n (pup_rst_n),
    .ref_tick  (ref_tick),
    .test_sel  (test_sel),
    .pol_swap  (pol_swap),
    .locked    (locked),
    .ref_lvl   (ref_lvl),
    .fb_lvl    (fb_lvl),
    .up_q      (up_q),
    .dn_q      (dn_q),
    .cp_src_en (cp_src_en),
    .cp_snk_en (cp_snk_en),
    .cp_hiz_en (cp_hiz_en),
    .ld_out    (ld_out)
  );
endmodule

// File: rtl/refpfd_checker.sv
`timescale 1ns/1ps
module refpfd_checker
  import refpfd_pkg::*;
#(
  parameter int unsigned DIV_A = 12,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 24
) (
  input logic       clk,
  input logic       pup_rst_n,
  input logic [1:0] ratio_sel,
  input logic       pol_swap,
  input logic [2:0] test_sel,
  input logic       fb_div_in,
  input logic       ref_tick,
  input logic       fb_rise,
  input logic       up_q,
  input logic       dn_q,
  input logic       good_evt,
  input logic       viol_evt,
  input logic       locked,
  input logic       cp_src_en,
  input logic       cp_snk_en,
  input logic       cp_hiz_en,
  input logic       ld_out
);
  int unsigned gap_q;
  logic        have_prev;
  logic [1:0]  ratio_q;

  // Cycles between reference events, restarted on reset or ratio change.
  always_ff @(posedge clk) begin
    ratio_q <= ratio_sel;
    if (!pup_rst_n || ratio_sel != ratio_q) begin
      gap_q     <= 0;
      have_prev <= 1'b0;
    end else if (ref_tick) begin
      gap_q     <= 0;
      have_prev <= 1'b1;
    end else begin
      gap_q     <= gap_q + 1;
    end
  end

  a_r1_tick_period: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (ref_tick && have_prev && ratio_sel == ratio_q)
      |-> (gap_q + 1 == ratio_of(ratio_sel, DIV_A, DIV_B, DIV_C)));

  a_r2_illegal_idle: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (ratio_sel == 2'b00) |-> (!ref_tick ##1 (!up_q && !dn_q && !locked)));

  a_r3_source_lead: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (up_q && !dn_q && !test_sel[2] && !pol_swap) |-> (cp_src_en && !cp_snk_en));

  a_r4_swapped_sink: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (up_q && !dn_q && !test_sel[2] && pol_swap) |-> (cp_snk_en && !cp_src_en));

  a_r5_both_hiz: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (up_q && dn_q) |-> cp_hiz_en);

  a_r6_clear_next: assert property (@(posedge clk) disable iff (!pup_rst_n)
    (up_q && dn_q && !ref_tick && !fb_rise) |=> (!up_q && !dn_q));

  a_r7_fb_route: assert property (@(posedge clk) disable iff (!pup_rst_n)
    ($past(pup_rst_n) && test_sel == 3'b010) |-> (ld_out == $past(fb_div_in)));

  a_r8_forced_hiz: assert property (@(posedge clk) disable iff (!pup_rst_n)
    test_sel[2] |-> (cp_hiz_en && !cp_src_en && !cp_snk_en));

  a_r9_lock_after_good: assert property (@(posedge clk) disable iff (!pup_rst_n)
    $rose(locked) |-> $past(good_evt));

  a_r10_lock_drop: assert property (@(posedge clk) disable iff (!pup_rst_n)
    viol_evt |=> !locked);

  a_r11_powerup_clear: assert property (@(posedge clk)
    !pup_rst_n |=> (!up_q && !dn_q && !locked && cp_hiz_en));
endmodule

bind refpfd_top refpfd_checker #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_chk (
  .clk       (clk),
  .pup_rst_n (pup_rst_n),
  .ratio_sel (ratio_sel),
  .pol_swap  (pol_swap),
  .test_sel  (test_sel),
  .fb_div_in (fb_div_in),
  .ref_tick  (ref_tick),
  .fb_rise   (fb_rise),
  .up_q      (up_q),
  .dn_q      (dn_q),
  .good_evt  (good_evt),
  .viol_evt  (viol_evt),
  .locked    (locked),
  .cp_src_en (cp_src_en),
  .cp_snk_en (cp_snk_en),
  .cp_hiz_en (cp_hiz_en),
  .ld_out    (ld_out)
);

// File: tb/test_refpfd_top.sv
`timescale 1ns/1ps
module test_refpfd_top;
  logic       clk       = 1'b0;
  logic       pup_rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b01;
  logic       pol_swap  = 1'b0;
  logic [2:0] test_sel  = 3'b000;
  logic       fb_div_in = 1'b0;
  logic       cp_src_en, cp_snk_en, cp_hiz_en, ld_out;

  int unsigned cyc = 0;
  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic        finished = 1'b0;

  typedef struct {
    int unsigned cyc;
    int          sig;
    logic        val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  refpfd_top i_refpfd_top (
    .clk       (clk),
    .pup_rst_n (pup_rst_n),
    .ratio_sel (ratio_sel),
    .pol_swap  (pol_swap),
    .test_sel  (test_sel),
    .fb_div_in (fb_div_in),
    .cp_src_en (cp_src_en),
    .cp_snk_en (cp_snk_en),
    .cp_hiz_en (cp_hiz_en),
    .ld_out    (ld_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic observe(input int s);
    case (s)
      0:       return cp_src_en;
      1:       return cp_snk_en;
      2:       return cp_hiz_en;
      default: return ld_out;
    endcase
  endfunction

  function automatic string sig_name(input int s);
    case (s)
      0:       return "cp_src_en";
      1:       return "cp_snk_en";
      2:       return "cp_hiz_en";
      default: return "ld_out";
    endcase
  endfunction

  task automatic expect_at(input int unsigned c, input int s, input logic v, input string tag);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: samples 2 ns after each falling edge and retires due items.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc <= cyc) begin
          n_chk++;
          if (exp_q[i].cyc < cyc || observe(exp_q[i].sig) !== exp_q[i].val) begin
            n_fail++;
            $display("FAIL %s cyc=%0d %s actual=%b expected=%b", exp_q[i].tag,
                     exp_q[i].cyc, sig_name(exp_q[i].sig), observe(exp_q[i].sig),
                     exp_q[i].val);
          end
          exp_q.delete(i);
        end
      end
    end
  end

  // One comparison: reference event lands at cycle t, feedback d cycles later.
  task automatic pfd_round(input int unsigned t, input int unsigned d, input logic pol,
                           input logic [2:0] tsel, input string tag);
    wait_cyc(t - 2);
    pol_swap = pol;
    test_sel = tsel;
    for (int unsigned k = 0; k < d; k++) begin
      expect_at(t + k, 0, !tsel[2] && !pol, tag);
      expect_at(t + k, 1, !tsel[2] && pol, tag);
      expect_at(t + k, 2, tsel[2], tag);
    end
    expect_at(t + d, 0, 1'b0, "R5");
    expect_at(t + d, 2, 1'b1, "R5");
    expect_at(t + d + 1, 2, 1'b1, "R6");
    wait_cyc(t + d - 1);
    fb_div_in = 1'b1;
    wait_cyc(t + d + 3);
    fb_div_in = 1'b0;
  endtask

  initial begin
    int unsigned rel;
    int unsigned t;
    int unsigned c;
    @(negedge clk);
    // R11: held in power-down
    expect_at(3, 0, 1'b0, "R11");
    expect_at(3, 1, 1'b0, "R11");
    expect_at(3, 2, 1'b1, "R11");
    expect_at(3, 3, 1'b0, "R11");
    rel = 5;
    wait_cyc(rel);
    pup_rst_n = 1'b1;

    // R3 R9: four short comparisons, lock after the fourth
    for (int unsigned m = 0; m < 4; m++) begin
      t = rel + 12 * (m + 1);
      expect_at(t + 2, 3, (m == 3), "R9");
      pfd_round(t, 1, 1'b0, 3'b000, (m == 0) ? "R3" : "R3 R6");
    end
    // R5: coincident events, lock kept
    t = rel + 12 * 5;
    expect_at(t, 1, 1'b0, "R5");
    expect_at(t + 1, 3, 1'b1, "R9");
    pfd_round(t, 0, 1'b0, 3'b000, "R5");
    // R4: polarity swapped
    t = rel + 12 * 6;
    expect_at(t + 2, 3, 1'b1, "R4");
    pfd_round(t, 1, 1'b1, 3'b000, "R4");
    // R8: forced high impedance, pin still shows lock
    t = rel + 12 * 7;
    expect_at(t, 3, 1'b1, "R8");
    expect_at(t + 2, 3, 1'b1, "R8");
    pfd_round(t, 1, 1'b0, 3'b100, "R8");
    // R10: three-cycle pulse drops lock in its second cycle
    t = rel + 12 * 8;
    expect_at(t + 1, 3, 1'b1, "R10");
    expect_at(t + 2, 3, 1'b0, "R10");
    pfd_round(t, 3, 1'b0, 3'b000, "R3 R10");

    // R7 R1: divided reference level on the pin, ratio 12
    t = rel + 12 * 9;
    wait_cyc(t - 2);
    test_sel = 3'b001;
    for (int unsigned j = 0; j < 24; j++) expect_at(t + j, 3, (j % 12) < 6, "R7 R1");
    wait_cyc(t + 24);

    // R7: sampled feedback one cycle late
    c = cyc;
    test_sel = 3'b010;
    fb_div_in = 1'b1;
    expect_at(c, 3, 1'b0, "R7");
    expect_at(c + 1, 3, 1'b1, "R7");
    expect_at(c + 2, 3, 1'b1, "R7");
    wait_cyc(c + 3);
    fb_div_in = 1'b0;
    expect_at(c + 4, 3, 1'b0, "R7");
    wait_cyc(c + 6);

    // R8: divide-by-2 route with forced high impedance
    c = cyc;
    test_sel = 3'b111;
    for (int unsigned u = c + 1; u < c + 25; u++) begin
      expect_at(u, 3, ((u - rel) / 12) % 2 == 1, "R8");
      if (u % 6 == 0) begin
        expect_at(u, 2, 1'b1, "R8");
        expect_at(u, 0, 1'b0, "R8");
      end
    end
    wait_cyc(c + 26);

    // R7: divide-by-2048 route
    test_sel = 3'b011;
    expect_at(rel + 12 * 1024 - 1, 3, 1'b0, "R7");
    expect_at(rel + 12 * 1024, 3, 1'b1, "R7");
    expect_at(rel + 12 * 1024 + 11, 3, 1'b1, "R7");
    wait_cyc(rel + 12 * 1024 + 12);

    // R11: power-down mid run
    c = cyc;
    test_sel = 3'b000;
    pup_rst_n = 1'b0;
    expect_at(c + 1, 3, 1'b0, "R11");
    expect_at(c + 1, 2, 1'b1, "R11");
    expect_at(c + 1, 0, 1'b0, "R11");
    wait_cyc(c + 2);
    pup_rst_n = 1'b1;
    wait_cyc(c + 20);

    // R2: illegal ratio, feedback edge ignored
    c = cyc;
    ratio_sel = 2'b00;
    test_sel = 3'b001;
    for (int unsigned k = 0; k < 30; k++) begin
      expect_at(c + k, 3, 1'b0, "R2");
      if (k > 0) expect_at(c + k, 2, 1'b1, "R2");
    end
    wait_cyc(c + 5);
    fb_div_in = 1'b1;
    wait_cyc(c + 9);
    fb_div_in = 1'b0;
    wait_cyc(c + 30);

    // R1: ratio 16, then 24
    c = cyc;
    ratio_sel = 2'b10;
    for (int unsigned k = 0; k < 32; k++) expect_at(c + k, 3, (k % 16) < 8, "R1");
    wait_cyc(c + 32);
    ratio_sel = 2'b00;
    wait_cyc(c + 34);
    c = cyc;
    ratio_sel = 2'b11;
    for (int unsigned k = 0; k < 48; k++) expect_at(c + k, 3, (k % 24) < 12, "R1");
    wait_cyc(c + 50);

    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 40000);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule